// File: doc/BRIEF.md
# Synchronous RAM Access Port with Burst Address Counter

This block is one clocked access port of a synchronous static RAM. Every rising clock edge it samples its controls and performs at most one read or write on a small internal array. The address of that access comes from one of four places: the external address pins, the internal counter plus one, the internal counter unchanged, or zero. This lets a host present a single starting address and then stream a burst of sequential accesses. It can also repeat an address, or restart from word 0, without wasting a cycle.

The data word is split into two byte lanes, and each lane has its own active-low write enable. Read data passes through one output register. The data pins are driven only in the cycle after a selected read and are high-impedance otherwise. The counter takes the access address on every edge, so an advance or a reset is applied to the access in the same cycle. The counter also follows its controls when the port is not selected.

Top module: `sram_burst_port`

## Requirements
- R1: A cycle is selected only when `ce_lo_n` is 0 and `ce_hi` is 1. An unselected cycle writes nothing, and the data pins are high-impedance after its edge.
- R2: When `clr_n` is 0, the access of that cycle goes to word 0 and the counter becomes 0, with no extra cycle.
- R3: When `clr_n` is 1 and `load_n` is 0, the access goes to `addr_in` and the counter keeps that address, so later advances continue from it.
- R4: When `clr_n`, `load_n` are 1 and `adv_n` is 0, the access goes to counter+1 in the same cycle and the counter keeps that value. Word 2^AW-1 is followed by word 0.
- R5: When `clr_n`, `load_n` and `adv_n` are all 1, the access goes to the counter value again and the counter does not change.
- R6: Priority, highest first: counter reset, external load, advance, hold.
- R7: In a selected write (`wr_n` = 0), `lane_hi_n` = 0 updates bits 17:9 and `lane_lo_n` = 0 updates bits 8:0 of the addressed word. A lane whose enable is 1 keeps its old value.
- R8: A selected read (`wr_n` = 1) places the addressed word on `rdata` after that edge, and the word stays there until the next edge.
- R9: After a selected write, `rdata` is high-impedance until the next edge.
- R10: Synchronous reset (`rst` = 1) clears the counter to 0 and puts `rdata` in high-impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling is on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ce_lo_n | input | 1 | Active-low chip select |
| ce_hi | input | 1 | Active-high chip select |
| wr_n | input | 1 | 0 = write, 1 = read |
| lane_hi_n | input | 1 | Active-low enable for bits 17:9 |
| lane_lo_n | input | 1 | Active-low enable for bits 8:0 |
| load_n | input | 1 | Active-low external address load |
| adv_n | input | 1 | Active-low counter advance |
| clr_n | input | 1 | Active-low counter reset to 0 |
| addr_in | input | AW | External address |
| wdata | input | 18 | Write data |
| rdata | output | 18 | Registered read data, high-impedance unless the previous cycle was a selected read |

## Verification
The bench goes after the cycle in which an advance or a counter reset takes effect. A design that moved the counter one cycle late would read or write the old address and miss the expected word. It also covers conflicting controls, such as reset together with a load, or a load together with an advance. A wrong priority there would access the external address instead of word 0, or counter+1 instead of the loaded address. It checks the wrap from the top word to word 0, writes to a single byte lane, and writes while the port is deselected; a design that got these wrong would corrupt the lane or word that should be kept. Finally, it checks that the data pins float after writes and deselected cycles and are driven only after a selected read.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;

    localparam int LANE_W = 9;
    localparam int LANES  = 2;
    localparam int WORD_W = LANE_W * LANES;

    typedef enum logic [1:0] {
        SRC_ZERO = 2'd0,
        SRC_EXT  = 2'd1,
        SRC_INC  = 2'd2,
        SRC_KEEP = 2'd3
    } addr_src_e;

    typedef struct packed {
        logic       sel;
        logic       wr;
        logic [LANES-1:0] lane_en;
    } access_t;

    // Fixed priority: zero > external > increment > keep
    function automatic addr_src_e pick_src(input logic clr_n, input logic load_n,
                                           input logic adv_n);
        if (!clr_n)       return SRC_ZERO;
        else if (!load_n) return SRC_EXT;
        else if (!adv_n)  return SRC_INC;
        else              return SRC_KEEP;
    endfunction

endpackage

// File: rtl/burst_addr_unit.sv
module burst_addr_unit
    import sram_burst_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_n,
    input  logic          adv_n,
    input  logic          clr_n,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] acc_addr
);

    logic [AW-1:0] cnt_q;
    addr_src_e     src;

    always_comb begin
        src = pick_src(clr_n, load_n, adv_n);
        unique case (src)
            SRC_ZERO: acc_addr = '0;
            SRC_EXT:  acc_addr = addr_in;
            SRC_INC:  acc_addr = cnt_q + AW'(1);
            default:  acc_addr = cnt_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= acc_addr;
    end

    // R2
    clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_n |=> (cnt_q == '0));
    // R3
    load_take_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_n && !load_n) |=> (cnt_q == $past(addr_in)));
    // R4
    adv_step_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_n && load_n && !adv_n) |=> (cnt_q == $past(cnt_q) + AW'(1)));
    // R5
    hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_n && load_n && adv_n) |=> $stable(cnt_q));

endmodule

// File: rtl/lane_mem_array.sv
module lane_mem_array
    import sram_burst_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic [AW-1:0]     addr,
    input  logic              we,
    input  logic [LANES-1:0]  lane_en,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rd_word
);

    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && lane_en[g])
                mem[addr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rd_word[g*LANE_W +: LANE_W] = mem[addr];
    end

endmodule

// File: rtl/read_out_stage.sv
module read_out_stage
    import sram_burst_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_go,
    input  logic [WORD_W-1:0] rd_word,
    output logic              oe_q,
    output logic [WORD_W-1:0] q_reg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            oe_q  <= 1'b0;
            q_reg <= '0;
        end else begin
            oe_q <= rd_go;
            if (rd_go) q_reg <= rd_word;
        end
    end

    // R8
    rd_capture_chk: assert property (@(posedge clk) disable iff (rst)
        rd_go |=> (oe_q && q_reg == $past(rd_word)));
    // R9
    no_drive_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_go |=> !oe_q);

endmodule

// File: rtl/sram_burst_port.sv
module sram_burst_port
    import sram_burst_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_lo_n,
    input  logic              ce_hi,
    input  logic              wr_n,
    input  logic              lane_hi_n,
    input  logic              lane_lo_n,
    input  logic              load_n,
    input  logic              adv_n,
    input  logic              clr_n,
    input  logic [AW-1:0]     addr_in,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);

    access_t           acc;
    logic [AW-1:0]     acc_addr;
    logic [WORD_W-1:0] rd_word;
    logic [WORD_W-1:0] q_reg;
    logic              oe_q;

    always_comb begin
        acc.sel     = !ce_lo_n && ce_hi;
        acc.wr      = !wr_n;
        acc.lane_en = {!lane_hi_n, !lane_lo_n};
    end

    burst_addr_unit #(.AW(AW)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .load_n   (load_n),
        .adv_n    (adv_n),
        .clr_n    (clr_n),
        .addr_in  (addr_in),
        .acc_addr (acc_addr)
    );

    lane_mem_array #(.AW(AW)) u_mem (
        .clk     (clk),
        .addr    (acc_addr),
        .we      (acc.sel && acc.wr),
        .lane_en (acc.lane_en),
        .wdata   (wdata),
        .rd_word (rd_word)
    );

    read_out_stage u_out (
        .clk     (clk),
        .rst     (rst),
        .rd_go   (acc.sel && !acc.wr),
        .rd_word (rd_word),
        .oe_q    (oe_q),
        .q_reg   (q_reg)
    );

    assign rdata = oe_q ? q_reg : 'z;

    // R1
    desel_float_chk: assert property (@(posedge clk) disable iff (rst)
        (ce_lo_n || !ce_hi) |=> !oe_q);
    // R10
    rst_quiet_chk: assert property (@(posedge clk)
        rst |=> !oe_q);

endmodule

// File: tb/sim_sram_burst_port.sv
module sim_sram_burst_port;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 6;
    localparam int DEPTH      = 1 << AW;

    logic        clk = 0;
    logic        rst;
    logic        ce_lo_n, ce_hi, wr_n, lane_hi_n, lane_lo_n;
    logic        load_n, adv_n, clr_n;
    logic [AW-1:0] addr_in;
    logic [17:0] wdata;
    wire  [17:0] rdata;

    int tests = 0;
    int fails = 0;

    // behavioural model state
    int          m_cnt;
    logic [17:0] m_mem [DEPTH];
    logic        m_oe;
    logic [17:0] m_q;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_burst_port #(.AW(AW)) u0 (
        .clk(clk), .rst(rst), .ce_lo_n(ce_lo_n), .ce_hi(ce_hi), .wr_n(wr_n),
        .lane_hi_n(lane_hi_n), .lane_lo_n(lane_lo_n), .load_n(load_n),
        .adv_n(adv_n), .clr_n(clr_n), .addr_in(addr_in), .wdata(wdata),
        .rdata(rdata)
    );

    function automatic logic [17:0] pat(input int i);
        return 18'((i * 2731 + 17) ^ (i << 9));
    endfunction

    task automatic compare(input string tag);
        logic [17:0] exp;
        exp = m_oe ? m_q : 18'bz;
        tests++;
        if (rdata !== exp) begin
            fails++;
            $display("FAIL %s: rdata=%h expected=%h", tag, rdata, exp);
        end
    endtask

    // drive one cycle (at negedge), update model, check after the edge
    task automatic step(input string tag, input logic sel, input logic wr,
                        input logic hi, input logic lo, input logic ld,
                        input logic adv, input logic clr, input int a,
                        input logic [17:0] d);
        int acc;
        ce_lo_n = !sel; ce_hi = 1'b1;
        wr_n = !wr; lane_hi_n = !hi; lane_lo_n = !lo;
        load_n = !ld; adv_n = !adv; clr_n = !clr;
        addr_in = AW'(a); wdata = d;
        if (clr)      acc = 0;
        else if (ld)  acc = a % DEPTH;
        else if (adv) acc = (m_cnt + 1) % DEPTH;
        else          acc = m_cnt;
        if (sel && wr) begin
            if (hi) m_mem[acc][17:9] = d[17:9];
            if (lo) m_mem[acc][8:0]  = d[8:0];
        end
        if (sel && !wr) m_q = m_mem[acc];
        m_oe  = sel && !wr;
        m_cnt = acc;
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 30000);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst = 1; ce_lo_n = 1; ce_hi = 0; wr_n = 1; lane_hi_n = 1; lane_lo_n = 1;
        load_n = 1; adv_n = 1; clr_n = 1; addr_in = '0; wdata = '0;
        m_cnt = 0; m_oe = 0; m_q = '0;
        @(negedge clk); @(negedge clk);
        compare("R10 reset floats output");
        rst = 0;

        // burst fill: load 0 then advance through every word
        step("R3 load write", 1, 1, 1, 1, 1, 0, 0, 0, pat(0));
        for (int i = 1; i < DEPTH; i++)
            step("R4 burst write", 1, 1, 1, 1, 0, 1, 0, 0, pat(i));
        compare("R9 float after write");
        // wrap: counter at top, advance reads word 0
        step("R4 wrap read", 1, 0, 0, 0, 0, 1, 0, 0, '0);
        step("R4 advance read", 1, 0, 0, 0, 0, 1, 0, 0, '0);
        // load mid then burst across the top
        step("R3 load read", 1, 0, 0, 0, 1, 0, 0, 60, '0);
        for (int i = 0; i < 5; i++)
            step("R4 burst read across wrap", 1, 0, 0, 0, 0, 1, 0, 0, '0);
        // hold
        step("R5 hold read", 1, 0, 0, 0, 0, 0, 0, 0, '0);
        step("R5 hold repeat write", 1, 1, 1, 1, 0, 0, 0, 0, 18'h2aaaa);
        step("R5 hold read back", 1, 0, 0, 0, 0, 0, 0, 0, '0);
        // counter reset with access in same cycle, with competing load
        step("R6 clr beats load", 1, 0, 0, 0, 1, 1, 1, 33, '0);
        step("R2 clr write", 1, 1, 1, 1, 0, 0, 1, 0, 18'h15555);
        step("R2 read word0", 1, 0, 0, 0, 0, 0, 0, 0, '0);
        step("R6 load beats advance", 1, 0, 0, 0, 1, 1, 0, 20, '0);
        step("R3 advance after load", 1, 0, 0, 0, 0, 1, 0, 0, '0);
        // byte lanes
        step("R7 upper lane write", 1, 1, 1, 0, 1, 0, 0, 10, 18'h3ffff);
        step("R7 read upper lane", 1, 0, 0, 0, 0, 0, 0, 0, '0);
        step("R7 lower lane write", 1, 1, 0, 1, 0, 0, 0, 0, 18'h00000);
        step("R7 read lower lane", 1, 0, 0, 0, 0, 0, 0, 0, '0);
        step("R7 no lane write", 1, 1, 0, 0, 0, 0, 0, 0, 18'h12345);
        step("R7 read no lane", 1, 0, 0, 0, 0, 0, 0, 0, '0);
        // deselected write ignored, output floats
        step("R1 deselected write", 0, 1, 1, 1, 1, 0, 0, 11, 18'h0f0f0);
        step("R1 read after deselect", 1, 0, 0, 0, 1, 0, 0, 11, '0);
        step("R1 deselected read floats", 0, 0, 0, 0, 0, 0, 0, 0, '0);
        step("R8 read then write", 1, 0, 0, 0, 1, 0, 0, 5, '0);
        step("R9 write floats", 1, 1, 1, 1, 0, 1, 0, 0, 18'h00abc);
        // random mix against the model
        for (int i = 0; i < 2000; i++) begin
            int r;
            r = $urandom;
            step("R8 random mix", (r[3:0] != 0), r[4], r[5], r[6],
                 (r[10:7] == 0), r[11], (r[16:12] == 0), int'(r[27:22]),
                 18'($urandom));
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule